// File: doc/BRIEF.md
# Audio Clock Regeneration Cycle-Time Meter

This block produces the cycle-time-stamp (CTS) value that an HDMI source sends so that the sink can rebuild its audio clock. The audio side runs on a reference clock at 128 times the sample rate. A divider in that domain counts the reference down by a programmed divisor N and flips a window flag at the end of each period. The flag crosses into the video (TMDS) clock domain through a synchronizer, and each of its edges marks a window boundary there. A counter in the video domain measures how many video clock cycles fall between two boundaries. That count is the CTS, and the sink uses the ratio N/CTS to rebuild 128×fs from the video clock.

At every window boundary the block presents a CTS value, the N that applies to it, and a one-cycle valid strobe to the packet builder. A mode input selects between the measured count and a value supplied from outside. The first windows after a reset or after a change of N are partial or mixed, so they are dropped. A divisor of zero stops the block.

Top module: `acr_cts_gen`

## Requirements
- R1: With N nonzero, the audio-domain divider marks a window boundary every N cycles of the audio reference clock, so a measured CTS equals N times the ratio of the video clock frequency to the reference frequency.
- R2: In automatic mode, cts_out is the number of video clock cycles between the previous boundary and the current one. The counter restarts at each boundary without losing a cycle, so consecutive valid strobes are exactly CTS video cycles apart. The count saturates at all ones and never wraps.
- R3: cts_valid is high for exactly one video clock per reported window. cts_out and n_out change only in the cycle where cts_valid is high and hold their values in between.
- R4: After a video-domain reset, and after any change of n_value, the first two window boundaries produce no strobe. The first reported value covers a complete window of the new N.
- R5: When cts_auto is 0, each strobe reports cts_manual in place of the measured count, with the same boundary timing and discard rules.
- R6: When n_value is zero the divider stops producing boundaries and cts_valid stays low.
- R7: While vid_rst is high and in the cycle after it is released, cts_out, n_out and cts_valid are all zero.
- R8: n_out carries the N that was in force for the window whose CTS is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aud_clk | input | 1 | Audio reference clock at 128×fs |
| aud_rst | input | 1 | Synchronous active-high reset, audio domain |
| vid_clk | input | 1 | Video / TMDS character clock |
| vid_rst | input | 1 | Synchronous active-high reset, video domain |
| n_value | input | N_W (20) | Divisor N, a quasi-static configuration value |
| cts_auto | input | 1 | 1 = report the measured count, 0 = report cts_manual |
| cts_manual | input | CTS_W (20) | Value reported when cts_auto is 0 |
| cts_out | output | CTS_W (20) | CTS value for the latest window |
| n_out | output | N_W (20) | N that applies to cts_out |
| cts_valid | output | 1 | One-cycle strobe marking a new cts_out / n_out pair |

## Verification
The bench builds the block with its default parameters: 20-bit N and CTS fields and a two-stage synchronizer. It drives several ratios between the reference clock and the 100 MHz video clock, with all clock edges phase-offset so that every expected CTS is an exact integer. One vector uses the 48 kHz divisor of 6144 and gives a window of 24576 video cycles, which exercises the wide counter and long gaps between strobes. Every vector changes N, so the two-boundary discard is checked at each change. The exact spacing between strobes checks that the counter restarts without losing a cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;
  // Video-domain measurement progress after reset or a divisor change.
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ARM1 = 2'd1,
    MS_ARM2 = 2'd2,
    MS_RUN  = 2'd3
  } meter_state_e;
endpackage

// File: rtl/acr_aud_divider.sv
module acr_aud_divider #(
  parameter int N_W = 20
) (
  input  logic           aud_clk,
  input  logic           aud_rst,
  input  logic [N_W-1:0] n_in,
  output logic           win_tgl
);
  logic [N_W-1:0] n_s1, n_s2, n_cur, cnt;

  always_ff @(posedge aud_clk) begin
    if (aud_rst) begin
      n_s1    <= '0;
      n_s2    <= '0;
      n_cur   <= '0;
      cnt     <= '0;
      win_tgl <= 1'b0;
    end else begin
      n_s1 <= n_in;
      n_s2 <= n_s1;
      if (n_s2 != n_cur) begin
        n_cur <= n_s2;
        cnt   <= '0;
      end else if (n_cur != '0) begin
        if (cnt == n_cur - 1'b1) begin
          cnt     <= '0;
          win_tgl <= ~win_tgl;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: a zero divisor freezes the window flag
  a_r6_hold_when_zero: assert property (@(posedge aud_clk) disable iff (aud_rst)
    (n_cur == '0) |=> $stable(win_tgl));

  // R1: the period counter stays below the divisor
  a_r1_cnt_below_n: assert property (@(posedge aud_clk) disable iff (aud_rst)
    (n_cur != '0) |-> (cnt < n_cur));
endmodule

// File: rtl/acr_toggle_sync.sv
module acr_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sr;
  logic              hist;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b0;
          else     sr[0] <= tgl_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[g] <= 1'b0;
          else     sr[g] <= sr[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist <= 1'b0;
    else     hist <= sr[LAST];
  end

  assign edge_o = sr[LAST] ^ hist;
endmodule

// File: rtl/acr_cts_meter.sv
module acr_cts_meter
  import acr_pkg::*;
#(
  parameter int N_W   = 20,
  parameter int CTS_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_edge,
  input  logic [N_W-1:0]   n_in,
  input  logic             cts_auto,
  input  logic [CTS_W-1:0] cts_manual,
  output logic [CTS_W-1:0] cts_out,
  output logic [N_W-1:0]   n_out,
  output logic             cts_valid
);
  localparam logic [CTS_W-1:0] CNT_MAX = {CTS_W{1'b1}};

  meter_state_e     state;
  logic [N_W-1:0]   n_seen;
  logic [CTS_W-1:0] cnt, cnt_inc;
  logic             n_change;

  assign n_change = (n_in != n_seen);
  assign cnt_inc  = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

  // Cycle counter: restarts on every boundary, saturates otherwise
  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (win_edge) cnt <= '0;
    else               cnt <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MS_IDLE;
      n_seen    <= '0;
      cts_out   <= '0;
      n_out     <= '0;
      cts_valid <= 1'b0;
    end else begin
      cts_valid <= 1'b0;
      if (n_change) begin
        n_seen <= n_in;
        state  <= (n_in == '0) ? MS_IDLE : MS_ARM1;
      end else if (win_edge) begin
        case (state)
          MS_ARM1: state <= MS_ARM2;
          MS_ARM2: state <= MS_RUN;
          MS_RUN: begin
            cts_valid <= 1'b1;
            cts_out   <= cts_auto ? cnt_inc : cts_manual;
            n_out     <= n_seen;
          end
          default: state <= MS_IDLE;
        endcase
      end
    end
  end

  // R4: a divisor change suppresses the strobe
  a_r4_no_valid_on_change: assert property (@(posedge clk) disable iff (rst)
    n_change |=> !cts_valid);

  // R6: a strobe never reports a zero divisor
  a_r6_valid_nonzero_n: assert property (@(posedge clk) disable iff (rst)
    cts_valid |-> (n_out != '0));

  // R2: the counter saturates and does not wrap
  a_r2_cnt_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0));

  // R3: outputs change only alongside the strobe
  a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cts_out) || !$stable(n_out)) |-> cts_valid);
endmodule

// File: rtl/acr_cts_gen.sv
module acr_cts_gen #(
  parameter int N_W         = 20,
  parameter int CTS_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             aud_clk,
  input  logic             aud_rst,
  input  logic             vid_clk,
  input  logic             vid_rst,
  input  logic [N_W-1:0]   n_value,
  input  logic             cts_auto,
  input  logic [CTS_W-1:0] cts_manual,
  output logic [CTS_W-1:0] cts_out,
  output logic [N_W-1:0]   n_out,
  output logic             cts_valid
);
  logic win_tgl;
  logic win_edge;

  acr_aud_divider #(.N_W(N_W)) u_div (
    .aud_clk (aud_clk),
    .aud_rst (aud_rst),
    .n_in    (n_value),
    .win_tgl (win_tgl)
  );

  acr_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (vid_clk),
    .rst    (vid_rst),
    .tgl_in (win_tgl),
    .edge_o (win_edge)
  );

  acr_cts_meter #(.N_W(N_W), .CTS_W(CTS_W)) u_meter (
    .clk        (vid_clk),
    .rst        (vid_rst),
    .win_edge   (win_edge),
    .n_in       (n_value),
    .cts_auto   (cts_auto),
    .cts_manual (cts_manual),
    .cts_out    (cts_out),
    .n_out      (n_out),
    .cts_valid  (cts_valid)
  );

  // R7: the cycle after video reset shows cleared outputs
  a_r7_reset_clear: assert property (@(posedge vid_clk)
    $past(vid_rst) |-> (!cts_valid && cts_out == '0 && n_out == '0));
endmodule

// File: tb/test_acr_cts_gen.sv
module test_acr_cts_gen;
  localparam int N_W   = 20;
  localparam int CTS_W = 20;
  localparam int NV    = 5;
  localparam int VN [NV] = '{6, 10, 7, 3, 6144};
  localparam int VH [NV] = '{20, 15, 25, 20, 20};

  logic             aud_clk = 1'b0;
  logic             vid_clk = 1'b0;
  logic             aud_rst, vid_rst;
  logic [N_W-1:0]   n_value;
  logic             cts_auto;
  logic [CTS_W-1:0] cts_manual;
  logic [CTS_W-1:0] cts_out;
  logic [N_W-1:0]   n_out;
  logic             cts_valid;

  int aud_half = 20;
  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  acr_cts_gen #(.N_W(N_W), .CTS_W(CTS_W)) i_acr_cts_gen (
    .aud_clk(aud_clk), .aud_rst(aud_rst), .vid_clk(vid_clk), .vid_rst(vid_rst),
    .n_value(n_value), .cts_auto(cts_auto), .cts_manual(cts_manual),
    .cts_out(cts_out), .n_out(n_out), .cts_valid(cts_valid)
  );

  initial forever #5 vid_clk = ~vid_clk;
  initial begin
    #3;
    forever #(aud_half) aud_clk = ~aud_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  always @(posedge vid_clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  // Waits for the next strobe; cycles counts negedges including `start`.
  task automatic wait_valid(input int limit, input int start, output bit got, output int cycles);
    got = 1'b0;
    cycles = start;
    for (int k = 0; k < limit; k++) begin
      @(negedge vid_clk);
      cycles++;
      if (cts_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    bit got;
    int cycles, exp;
    aud_rst = 1'b1; vid_rst = 1'b1;
    n_value = '0; cts_auto = 1'b1; cts_manual = '0;
    repeat (6) @(negedge vid_clk);
    aud_rst = 1'b0; vid_rst = 1'b0;
    @(negedge vid_clk);
    // R7: reset state
    check("R7 reset cts_out", int'(cts_out), 0);
    check("R7 reset n_out", int'(n_out), 0);
    check("R7 reset valid", int'(cts_valid), 0);

    // Vector table: each entry changes N and the reference period
    for (int i = 0; i < NV; i++) begin
      exp = VN[i] * 2 * VH[i] / 10;
      @(negedge vid_clk);
      n_value  = N_W'(VN[i]);
      aud_half = VH[i];
      wait_valid(100000, 0, got, cycles);
      check("R4 first strobe after N change arrives", int'(got), 1);
      check("R1/R4 first CTS after change", int'(cts_out), exp);
      check("R8 n_out", int'(n_out), VN[i]);
      @(negedge vid_clk);
      check("R3 strobe is one cycle", int'(cts_valid), 0);
      wait_valid(100000, 1, got, cycles);
      check("R2 strobe spacing equals CTS", cycles, exp);
      check("R2 second CTS", int'(cts_out), exp);
    end

    // R5: manual value replaces the measurement
    @(negedge vid_clk);
    cts_auto   = 1'b0;
    cts_manual = 20'h5A5A5;
    n_value    = 20'd9;
    aud_half   = 20;
    wait_valid(5000, 0, got, cycles);
    check("R5 manual CTS", int'(cts_out), 32'h5A5A5);
    check("R8 n_out manual", int'(n_out), 9);
    @(negedge vid_clk);
    cts_auto = 1'b1;

    // R6: zero divisor keeps the strobe low
    n_value = '0;
    wait_valid(2000, 0, got, cycles);
    check("R6 no strobe with N zero", int'(got), 0);
    check("R3 outputs held with N zero", int'(n_out), 9);

    // R7/R4: mid-run video reset, then a clean first window
    @(negedge vid_clk);
    n_value = 20'd5;
    repeat (200) @(negedge vid_clk);
    vid_rst = 1'b1;
    repeat (3) @(negedge vid_clk);
    vid_rst = 1'b0;
    @(negedge vid_clk);
    check("R7 cts_out after reset", int'(cts_out), 0);
    check("R7 n_out after reset", int'(n_out), 0);
    wait_valid(5000, 0, got, cycles);
    check("R4 first CTS after reset", int'(cts_out), 20);
    check("R8 n_out after reset", int'(n_out), 5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule